// File: doc/BRIEF.md
# Auto-Restart Fault Supervisor

This block is the digital sequencer that decides when an off-line switching power stage may switch. It watches the control-supply window through two comparator flags (upper threshold reached, lower threshold reached). It also watches a power-up-reset flag, an over-temperature flag and an overcurrent flag on the control input. From these it drives the enable of the high-voltage start-up current source, the enable of the PWM and output switch, and a latched-shutdown status.

After reset the block charges the supply. The first upper crossing starts switching. If the supply sags to the lower threshold while the stage is switching, the block stops the switch and regulates the supply hysteretically by turning the current source on and off. It permits switching again only after a fixed number of complete discharge-charge cycles, eight by default, which keeps the average dissipation during a persistent fault low. An overcurrent pulse or an over-temperature flag sets a shutdown latch. Only a power-up reset clears it, and the hysteretic supply regulation continues while the latch is set. All flags are asynchronous to the clock and pass through a two-flop synchronizer inside the block.

Top module: `restart_supervisor`

## Requirements
- R1: After reset the current source is enabled, the switch is disabled and the shutdown status is clear.
- R2: In start-up charging, the first rising edge of the upper-threshold flag disables the current source and enables the switch.
- R3: While switching, a high lower-threshold flag disables the switch and enables the current source (restart charging).
- R4: During restart or latched operation, the current source turns off on a rising upper-threshold edge and turns back on when the lower-threshold flag is high; the switch stays off.
- R5: After a fault, the switch is enabled again on the RESTART_CYCLES-th (default 8th) rising upper-threshold edge counted from the fault, and not on any earlier edge.
- R6: While switching, activity on the upper-threshold flag with the lower flag low leaves the switch enabled.
- R7: A pulse on the overcurrent flag sets the shutdown status and disables the switch.
- R8: A high over-temperature flag sets the shutdown status and disables the switch.
- R9: The shutdown status is cleared only by the power-up-reset flag, which also returns the block to start-up charging with the cycle count at zero; when set and clear arrive together, the clear wins.
- R10: While the shutdown status is set, the switch is never enabled, no matter how many supply cycles pass.
- R11: Every input flag passes two synchronizer flops, so an output responds on the third rising clock edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_upper | input | 1 | Supply at or above the upper threshold |
| vc_lower | input | 1 | Supply at or below the lower threshold |
| por_req | input | 1 | Supply below the power-up-reset level |
| over_temp | input | 1 | Junction over-temperature |
| ctl_overcurrent | input | 1 | High-current pulse on the control input |
| hv_src_en | output | 1 | Enable of the start-up current source |
| sw_en | output | 1 | Enable of the PWM and output switch |
| latched_off | output | 1 | Shutdown latch status |

## Verification
Two functions can fall in the same cycle: the shutdown latch can see its set (overcurrent or over-temperature) and its clear (power-up reset) together, and a fault can arrive while the restart counter is one edge from its terminal value. The bench drives both flags in the same clock period and expects the latch clear and the block back in start-up charging. It also sets the latch partway through a restart sequence and then runs more supply cycles than the terminal count, expecting the switch to stay off. Random event sequences mix supply rises, sags, fault pulses and reset pulses, and each event is judged against a bench model that steps once per event.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_BOOT   = 2'd0,
    ST_RUN    = 2'd1,
    ST_AR_CHG = 2'd2,
    ST_AR_DIS = 2'd3
  } rs_state_e;

  // current source is on only in the two charging phases
  function automatic logic src_on(rs_state_e s);
    return (s == ST_BOOT) || (s == ST_AR_CHG);
  endfunction
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rs_cycle_ctr.sv
module rs_cycle_ctr #(
  parameter int TERM = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] wrap_inc(logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  assign done = inc && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= wrap_inc(cnt_q);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("count beyond terminal"); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)) else $error("clear ignored"); // R9
endmodule

// File: rtl/rs_fault_latch.sv
module rs_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q) else $error("latch dropped"); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q) else $error("clear lost to set"); // R9
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor #(
  parameter int RESTART_CYCLES = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vc_upper,
  input  logic vc_lower,
  input  logic por_req,
  input  logic over_temp,
  input  logic ctl_overcurrent,
  output logic hv_src_en,
  output logic sw_en,
  output logic latched_off
);
  import rs_pkg::*;

  localparam int NFLAG = 5;

  logic [NFLAG-1:0] flag_raw, flag_s;
  logic upper_s, lower_s, por_s, ot_s, oc_s;
  logic upper_prev_q, upper_rise;
  logic fault_set, cnt_inc, cnt_clr, cnt_done;
  rs_state_e state_q, state_d;

  assign flag_raw = {ctl_overcurrent, over_temp, por_req, vc_lower, vc_upper};

  rs_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(flag_raw), .q(flag_s)
  );

  assign upper_s = flag_s[0];
  assign lower_s = flag_s[1];
  assign por_s   = flag_s[2];
  assign ot_s    = flag_s[3];
  assign oc_s    = flag_s[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upper_prev_q <= 1'b0;
    else        upper_prev_q <= upper_s;
  end

  // named internal events
  assign upper_rise = upper_s && !upper_prev_q;
  assign fault_set  = ot_s || oc_s;
  assign cnt_inc    = upper_rise && (state_q == ST_AR_CHG) && !latched_off && !por_s;
  assign cnt_clr    = por_s || ((state_q == ST_RUN) && lower_s);

  rs_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set(fault_set), .clr(por_s), .q(latched_off)
  );

  rs_cycle_ctr #(.TERM(RESTART_CYCLES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .done(cnt_done)
  );

  always_comb begin
    state_d = state_q;
    if (por_s) begin
      state_d = ST_BOOT;
    end else begin
      unique case (state_q)
        ST_BOOT:   if (upper_rise) state_d = latched_off ? ST_AR_DIS : ST_RUN;
        ST_RUN:    if (lower_s) state_d = ST_AR_CHG;
                   else if (latched_off) state_d = ST_AR_DIS;
        ST_AR_CHG: if (upper_rise) state_d = cnt_done ? ST_RUN : ST_AR_DIS;
        ST_AR_DIS: if (lower_s) state_d = ST_AR_CHG;
        default:   state_d = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_BOOT;
    else        state_q <= state_d;
  end

  assign hv_src_en = src_on(state_q);
  assign sw_en     = (state_q == ST_RUN) && !latched_off;

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && hv_src_en)) else $error("source and switch both on"); // R3
  AST_LATCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !sw_en) else $error("switch on while latched"); // R10
  AST_FIRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BOOT && upper_rise && !por_s && !latched_off && !fault_set)
      |=> (sw_en && !hv_src_en)) else $error("start-up missed"); // R2
  AST_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AR_CHG && upper_rise && !cnt_done && !por_s) |=> !sw_en)
    else $error("restart before terminal count"); // R5
  AST_POR_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> (state_q == ST_BOOT && !latched_off)) else $error("reset ignored"); // R9
  AST_SAG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && lower_s && !por_s) |=> (!sw_en && hv_src_en)) else $error("sag ignored"); // R3
endmodule

// File: tb/test_restart_supervisor.sv
module test_restart_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int RESTARTS   = 8;
  localparam int M_BOOT = 0, M_RUN = 1, M_CHG = 2, M_DIS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vc_upper = 0, vc_lower = 0, por_req = 0, over_temp = 0, ctl_overcurrent = 0;
  logic hv_src_en, sw_en, latched_off;

  int compared = 0, mismatched = 0;
  int m_mode = M_BOOT, m_cnt = 0;
  bit m_lat = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_supervisor #(.RESTART_CYCLES(RESTARTS)) i_restart_supervisor (
    .clk(clk), .rst_n(rst_n), .vc_upper(vc_upper), .vc_lower(vc_lower),
    .por_req(por_req), .over_temp(over_temp), .ctl_overcurrent(ctl_overcurrent),
    .hv_src_en(hv_src_en), .sw_en(sw_en), .latched_off(latched_off)
  );

  function automatic bit want_src(int mode);
    return (mode == M_BOOT) || (mode == M_CHG);
  endfunction
  function automatic bit want_sw(int mode, bit lat);
    return (mode == M_RUN) && !lat;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(string req);
    bit es, ew;
    es = want_src(m_mode);
    ew = want_sw(m_mode, m_lat);
    compared++;
    if (hv_src_en !== es || sw_en !== ew || latched_off !== m_lat) begin
      mismatched++;
      $display("FAIL %s src/sw/lat got %b%b%b expected %b%b%b", req,
               hv_src_en, sw_en, latched_off, es, ew, m_lat);
    end
  endtask

  // model steps once per event
  task automatic model_rise();
    case (m_mode)
      M_BOOT: m_mode = m_lat ? M_DIS : M_RUN;
      M_CHG: begin
        if (m_lat) m_mode = M_DIS;
        else begin
          m_cnt++;
          if (m_cnt == RESTARTS) begin m_mode = M_RUN; m_cnt = 0; end
          else m_mode = M_DIS;
        end
      end
      default: ;
    endcase
  endtask

  task automatic model_fall();
    if (m_mode == M_RUN) begin m_mode = M_CHG; m_cnt = 0; end
    else if (m_mode == M_DIS) m_mode = M_CHG;
  endtask

  task automatic ev_rise(string req);
    vc_upper = 0; vc_lower = 0; step(4);
    vc_upper = 1; step(4);
    model_rise(); cmp(req);
  endtask

  task automatic ev_fall(string req);
    vc_upper = 0; vc_lower = 0; step(4);
    vc_lower = 1; step(4);
    model_fall(); cmp(req);
  endtask

  task automatic ev_fault(bit thermal, string req);
    if (thermal) over_temp = 1; else ctl_overcurrent = 1;
    step(1);
    over_temp = 0; ctl_overcurrent = 0;
    step(4);
    m_lat = 1;
    if (m_mode == M_RUN) m_mode = M_DIS;
    cmp(req);
  endtask

  task automatic ev_por(bit with_fault, string req);
    por_req = 1;
    if (with_fault) ctl_overcurrent = 1;
    step(1);
    por_req = 0; ctl_overcurrent = 0;
    step(4);
    m_mode = M_BOOT; m_cnt = 0; m_lat = 0;
    cmp(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd2718);
    step(3);
    cmp("R1 reset state");
    rst_n = 1;
    step(2);
    cmp("R1 after release");

    // R11: latency of three rising edges
    vc_upper = 1;
    step(2);
    cmp("R11 no response after two edges");
    step(1);
    m_mode = M_RUN;
    cmp("R11 R2 response on third edge");

    // R6: upper flag toggles while running
    for (int k = 0; k < 3; k++) ev_rise("R6 running kept");

    ev_fall("R3 sag stops switch");

    // R4 / R5: restart sequence
    for (int k = 1; k < RESTARTS; k++) begin
      ev_rise("R4 R5 early edge keeps switch off");
      ev_fall("R4 source back on at lower");
    end
    ev_rise("R5 terminal edge restarts");

    // R7 then R10: latch during running, cycling beyond terminal count
    ev_fault(0, "R7 overcurrent latches");
    for (int k = 0; k < RESTARTS + 2; k++) begin
      ev_fall("R10 latched hysteresis on");
      ev_rise("R10 latched never switches");
    end

    ev_por(0, "R9 reset clears latch");
    ev_rise("R2 start after reset");
    ev_fault(1, "R8 over-temperature latches");
    ev_por(1, "R9 clear wins over set");
    ev_rise("R2 start after combined pulse");

    // fault one edge before terminal
    ev_fall("R3 sag");
    for (int k = 1; k < RESTARTS; k++) begin
      ev_rise("R5 edge");
      ev_fall("R4 lower");
    end
    ev_fault(0, "R7 latch near terminal");
    ev_rise("R10 terminal edge blocked");

    for (int k = 0; k < 400; k++) begin
      r = int'($urandom % 32);
      if (r < 14)      ev_rise("R4 R5 random rise");
      else if (r < 28) ev_fall("R3 R4 random fall");
      else if (r < 30) ev_fault(r[0], "R7 R8 random fault");
      else             ev_por(r[0], "R9 random reset");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule